// File: doc/BRIEF.md
# Indirect Branch Target Count Cache

This block predicts where an indirect branch will jump when that branch is not a subroutine return. It is a direct-mapped table that all hardware threads share. Each entry stores a predicted target address and a small saturating confidence counter. A lookup combines low fetch-address bits with the requesting thread's global branch history using XOR to form the index. One clock later the block returns the stored target, the entry's confidence, a flag that says whether the prediction is trustworthy, and the index it used.

The fetch logic keeps that index with the branch. When the branch resolves, it sends the index back with the actual target. The confidence counter then decides what happens. A correct target strengthens the entry. A wrong target weakens it. The stored target is overwritten only once confidence has dropped to zero. Return prediction, direction prediction and history maintenance are handled elsewhere, so the history bits arrive already formed.

Top module: `indirect_target_cache`

## Requirements
- R1: The table index is lkPc XOR lkHist, bit by bit, over IDX_W bits. It is reported on predIdx together with the prediction.
- R2: predValid is high in the cycle after a cycle with lkReq high, and low after a cycle with lkReq low. The outputs for a lookup appear on the clock edge after the request.
- R3: predConf reports the 2-bit confidence of the looked-up entry. predConfident is high exactly when predValid is high and that confidence is 2 or higher.
- R4: An update whose target equals the stored target, on an entry with nonzero confidence, increments the confidence. The count saturates at 3.
- R5: An update whose target differs from the stored target, on an entry with nonzero confidence, decrements the confidence. The stored target is left unchanged.
- R6: An update on an entry whose confidence is 0 writes the resolved target into that entry and sets its confidence to 1.
- R7: While the synchronous reset is high, predValid is low and updates are ignored. When reset ends, every entry has confidence 0.
- R8: If a lookup and an update hit the same entry in the same cycle, the lookup returns the contents from before the update. The update is visible to the next lookup.
- R9: The table is shared. An entry written through updIdx is returned by any lookup whose address and history bits hash to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkReq | input | 1 | Lookup request |
| lkPc | input | IDX_W | Fetch-address bits used for indexing |
| lkHist | input | IDX_W | Global history bits of the requesting thread |
| predValid | output | 1 | A prediction is present |
| predTarget | output | ADDR_W | Predicted target |
| predConf | output | CONF_W | Confidence of the looked-up entry |
| predConfident | output | 1 | Confidence is at or above the use threshold |
| predIdx | output | IDX_W | Index used, to be returned with the update |
| updReq | input | 1 | Resolved-branch update |
| updIdx | input | IDX_W | Index captured at prediction time |
| updTarget | input | ADDR_W | Resolved target |

## Verification
The bench builds the block with its default parameters: 128 entries, 62-bit targets, 2-bit confidence and a threshold of 2. Random updates are confined to eight indices, and each index draws from only two targets. This makes every counter climb to saturation, fall back to zero and get replaced many times within a short run. Directed steps cover the full confidence ladder on one entry, a lookup and an update to the same entry in the same cycle, aliasing through different address and history pairs, and a reset in the middle of the run.

// File: rtl/ibtc_pkg.sv
package ibtc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic lkCap;  // capture lookup result
    logic wrTgt;  // overwrite stored target at update index
  } ctlStrb_t;
endpackage

// File: rtl/ibtc_hash.sv
module ibtc_hash #(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] pcBits,
  input  logic [IDX_W-1:0] histBits,
  output logic [IDX_W-1:0] idx
);
  always_comb idx = pcBits ^ histBits;
endmodule

// File: rtl/ibtc_dp.sv
module ibtc_dp
  import ibtc_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 62
) (
  input  logic              clk,
  input  ctlStrb_t          strb,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              updHit,
  output logic [ADDR_W-1:0] predTarget,
  output logic [IDX_W-1:0]  predIdx
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ADDR_W-1:0] tgtMem [ENTRIES];

  always_comb updHit = (tgtMem[updIdx] == updTarget);

  always_ff @(posedge clk) begin
    if (strb.wrTgt) tgtMem[updIdx] <= updTarget;
    if (strb.lkCap) begin
      predTarget <= tgtMem[lkIdx];
      predIdx    <= lkIdx;
    end
  end
endmodule

// File: rtl/ibtc_ctl.sv
module ibtc_ctl
  import ibtc_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int CONF_W  = 2,
  parameter int USE_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkReq,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic              updReq,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic              updHit,
  output ctlStrb_t          strb,
  output logic              predValid,
  output logic [CONF_W-1:0] predConf,
  output logic              predConfident
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;
  localparam logic [CONF_W-1:0] CONF_ONE  = 1;
  localparam logic [CONF_W-1:0] USE_MIN_C = USE_MIN[CONF_W-1:0];

  logic [CONF_W-1:0] confMem [ENTRIES];
  logic [CONF_W-1:0] confOld;
  logic [CONF_W-1:0] confNew;
  logic              replace;

  always_comb begin
    confOld = confMem[updIdx];
    replace = 1'b0;
    confNew = confOld;
    if (confOld == '0) begin
      replace = 1'b1;
      confNew = CONF_ONE;
    end else if (updHit) begin
      confNew = (confOld == CONF_MAX) ? CONF_MAX : confOld + CONF_ONE;
    end else begin
      confNew = confOld - CONF_ONE;
    end
  end

  always_comb begin
    strb.lkCap = lkReq & ~rst;
    strb.wrTgt = updReq & replace & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) confMem[i] <= '0;
      predValid     <= 1'b0;
      predConf      <= '0;
      predConfident <= 1'b0;
    end else begin
      if (updReq) confMem[updIdx] <= confNew;
      predValid     <= lkReq;
      predConfident <= lkReq && (confMem[lkIdx] >= USE_MIN_C);
      if (lkReq) predConf <= confMem[lkIdx];
    end
  end
endmodule

// File: rtl/indirect_target_cache.sv
module indirect_target_cache
  import ibtc_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int ADDR_W  = 62,
  parameter int CONF_W  = 2,
  parameter int USE_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkReq,
  input  logic [IDX_W-1:0]  lkPc,
  input  logic [IDX_W-1:0]  lkHist,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic [CONF_W-1:0] predConf,
  output logic              predConfident,
  output logic [IDX_W-1:0]  predIdx,
  input  logic              updReq,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [ADDR_W-1:0] updTarget
);
  ctlStrb_t         ctlStrb;
  logic [IDX_W-1:0] lkIdx;
  logic             updHit;

  ibtc_hash #(.IDX_W(IDX_W)) hash_i (
    .pcBits(lkPc), .histBits(lkHist), .idx(lkIdx)
  );

  ibtc_ctl #(.IDX_W(IDX_W), .CONF_W(CONF_W), .USE_MIN(USE_MIN)) ctl_i (
    .clk(clk), .rst(rst), .lkReq(lkReq), .lkIdx(lkIdx),
    .updReq(updReq), .updIdx(updIdx), .updHit(updHit),
    .strb(ctlStrb), .predValid(predValid), .predConf(predConf),
    .predConfident(predConfident)
  );

  ibtc_dp #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .strb(ctlStrb), .lkIdx(lkIdx), .updIdx(updIdx),
    .updTarget(updTarget), .updHit(updHit),
    .predTarget(predTarget), .predIdx(predIdx)
  );
endmodule

// File: rtl/ibtc_chk.sv
module ibtc_chk #(
  parameter int IDX_W   = 7,
  parameter int CONF_W  = 2,
  parameter int USE_MIN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lkReq,
  input logic [IDX_W-1:0]  lkPc,
  input logic [IDX_W-1:0]  lkHist,
  input logic              predValid,
  input logic [CONF_W-1:0] predConf,
  input logic              predConfident,
  input logic [IDX_W-1:0]  predIdx,
  input logic              wrTgt,
  input logic [CONF_W-1:0] oldConf
);
  localparam logic [CONF_W-1:0] USE_MIN_C = USE_MIN[CONF_W-1:0];

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> predValid == $past(lkReq)); // R2
  AST_INDEX_HASH: assert property (@(posedge clk) disable iff (rst)
    (predValid && !$past(rst)) |-> predIdx == ($past(lkPc) ^ $past(lkHist))); // R1
  AST_CONFIDENT_GATED: assert property (@(posedge clk) disable iff (rst)
    predConfident |-> (predValid && predConf >= USE_MIN_C)); // R3
  AST_REPLACE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrTgt |-> oldConf == '0); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predValid); // R7
endmodule

bind indirect_target_cache ibtc_chk #(.IDX_W(IDX_W), .CONF_W(CONF_W), .USE_MIN(USE_MIN)) chk_i (
  .clk(clk), .rst(rst), .lkReq(lkReq), .lkPc(lkPc), .lkHist(lkHist),
  .predValid(predValid), .predConf(predConf), .predConfident(predConfident),
  .predIdx(predIdx), .wrTgt(ctlStrb.wrTgt), .oldConf(ctl_i.confOld)
);

// File: tb/indirect_target_cache_tb_top.sv
module indirect_target_cache_tb_top;
  localparam int IW = 7;
  localparam int AW = 62;
  localparam int ENT = 1 << IW;

  logic clk = 0;
  logic rst = 1;
  logic lkReq = 0;
  logic [IW-1:0] lkPc = '0, lkHist = '0;
  logic predValid, predConfident;
  logic [AW-1:0] predTarget;
  logic [1:0] predConf;
  logic [IW-1:0] predIdx;
  logic updReq = 0;
  logic [IW-1:0] updIdx = '0;
  logic [AW-1:0] updTarget = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  int mConf [ENT];
  logic [AW-1:0] mTgt [ENT];
  bit mKnown [ENT];

  always #10 clk = ~clk;

  indirect_target_cache dut_i (
    .clk(clk), .rst(rst), .lkReq(lkReq), .lkPc(lkPc), .lkHist(lkHist),
    .predValid(predValid), .predTarget(predTarget), .predConf(predConf),
    .predConfident(predConfident), .predIdx(predIdx),
    .updReq(updReq), .updIdx(updIdx), .updTarget(updTarget)
  );

  function automatic logic [AW-1:0] tgtFor(logic [IW-1:0] idx, bit sel);
    return {idx, sel, 54'h2B_3C4D_5E6F_7081};
  endfunction

  function automatic int nextConf(int c, bit hit);
    if (c == 0) return 1;
    if (hit) return (c == 3) ? 3 : c + 1;
    return c - 1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit lk, logic [IW-1:0] pc, logic [IW-1:0] h,
                      bit up, logic [IW-1:0] ui, logic [AW-1:0] ut, string tag);
    logic [IW-1:0] eIdx;
    int eConf;
    logic [AW-1:0] eTgt;
    bit eKnown;
    @(negedge clk);
    lkReq = lk; lkPc = pc; lkHist = h;
    updReq = up; updIdx = ui; updTarget = ut;
    eIdx = pc ^ h;
    eConf = mConf[eIdx];
    eTgt = mTgt[eIdx];
    eKnown = mKnown[eIdx];
    if (up) begin
      bit hit;
      hit = mKnown[ui] && (mTgt[ui] == ut);
      if (mConf[ui] == 0) begin
        mTgt[ui] = ut; mKnown[ui] = 1;
      end
      mConf[ui] = nextConf(mConf[ui], hit);
    end
    @(posedge clk);
    #1;
    chk("R2", "predValid", 64'(predValid), 64'(lk));
    if (lk) begin
      chk("R1", "predIdx", 64'(predIdx), 64'(eIdx));
      chk(tag, "predConf", 64'(predConf), 64'(eConf));
      chk(tag, "predConfident", 64'(predConfident), 64'(eConf >= 2));
      if (eKnown) chk(tag, "predTarget", 64'(predTarget), 64'(eTgt));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; lkReq = 0; updReq = 1; updIdx = 7'd5; updTarget = tgtFor(7'd5, 1);
    @(negedge clk);
    updReq = 0;
    rst = 0;
    for (int i = 0; i < ENT; i++) mConf[i] = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] tA, tB;
    void'($urandom(32'd4242));
    for (int i = 0; i < ENT; i++) begin
      mConf[i] = 0; mKnown[i] = 0; mTgt[i] = '0;
    end
    tA = tgtFor(7'd5, 0);
    tB = tgtFor(7'd5, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R7", "predValid at reset", 64'(predValid), 64'd0);

    step(1, 7'd5, 7'd0, 0, 0, 0, "R7");          // confidence 0 after reset
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 7'd5, tA, "R6");            // 0 -> 1, write A
    step(1, 7'd5, 7'd0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 7'd5, tA, "R4");            // 1 -> 2
    step(1, 7'd5, 7'd0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 7'd5, tA, "R4");            // 2 -> 3
    step(0, 0, 0, 1, 7'd5, tA, "R4");            // saturate
    step(1, 7'd5, 7'd0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 7'd5, tB, "R5");            // 3 -> 2 keep A
    step(1, 7'd5, 7'd0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 7'd5, tB, "R5");            // 2 -> 1
    step(0, 0, 0, 1, 7'd5, tB, "R5");            // 1 -> 0
    step(1, 7'd5, 7'd0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 7'd5, tB, "R6");            // replace with B, 1
    step(1, 7'd5, 7'd0, 1, 7'd5, tB, "R8");      // sees 1 while 1 -> 2
    step(1, 7'd5, 7'd0, 0, 0, 0, "R8");          // sees 2
    step(1, 7'h7A, 7'h7F, 0, 0, 0, "R9");        // aliases to index 5
    step(1, 7'h00, 7'h05, 0, 0, 0, "R9");
    doReset();
    step(1, 7'h05, 7'h00, 0, 0, 0, "R7");

    for (int n = 0; n < 4000; n++) begin
      logic [IW-1:0] ui, pc, h;
      bit lk, up;
      ui = IW'($urandom_range(7));
      h  = IW'($urandom);
      pc = h ^ IW'($urandom_range(7));
      lk = ($urandom_range(3) != 0);
      up = ($urandom_range(1) != 0);
      step(lk, pc, h, up, ui, tgtFor(ui, bit'($urandom_range(1))), "R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule